// File: doc/BRIEF.md
# Idle-time power mode sequencer

This block decides how often a motion sensor should take an image frame. It keeps count of timebase ticks since motion was last seen. As that count grows, it moves the sensor from a run state, where a frame is taken on every tick, down through three rest states. Each rest state polls less often than the one above it. When any motion is seen, the block goes back to run and the count starts again from zero.

Software can set a rest state by writing a two-bit code into the top two bits of a configuration byte. Writing the code zero hands control back to the automatic sequence. The current state can be read back from the same two bits. A separate control byte holds a power-down bit. Once that bit is set, all sampling stops until the block is reset. Every poll period and every inactivity threshold is a tick-count parameter, so a short simulation can use small values.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, mode_o is 00 (run), sample_en_o and pd_o are low, and cfg_rdata_o is 0x00.
- R2: In automatic operation the block counts ticks that arrive without motion. mode_o is 00 while the count is below IDLE1_TICKS, 01 from IDLE1_TICKS, 10 from IDLE2_TICKS and 11 from IDLE3_TICKS. The new code appears in the cycle after the clock edge that samples the threshold tick.
- R3: A motion_i pulse, when not powered down, clears the inactivity count. If it arrives in the same cycle as a tick, the motion wins. In automatic operation mode_o reads 00 from the next cycle.
- R4: In run mode, each sampled tick gives a one-cycle sample_en_o pulse in the following cycle. sample_en_o is never high unless tick_i was high in the previous cycle.
- R5: In rest mode k, sample_en_o pulses once every POLLk_TICKS ticks. The period count restarts when the mode changes, so the first pulse follows the POLLk_TICKS-th tick after the change.
- R6: A configuration write with cfg_wdata_i[7:6] nonzero sets mode_o to that code from the next cycle. The mode then stays there whatever the inactivity count does and whatever motion arrives.
- R7: A configuration write with cfg_wdata_i[7:6] = 00 returns the block to automatic operation and clears the inactivity count, so mode_o is 00 from the next cycle. Bits 5:0 of every configuration write are ignored.
- R8: cfg_rdata_o carries the current mode code in bits 7:6 and zeros in bits 5:0, whether the mode was forced or reached automatically.
- R9: A control write with ctrl_wdata_i[1] = 1 raises pd_o from the next cycle. The other control bits are ignored, and a control write with bit 1 clear has no effect.
- R10: While pd_o is high there are no sample_en_o pulses, mode_o holds, and motion, configuration writes and control writes have no effect. Only rst_n clears pd_o.
- R11: The inactivity count saturates, so with no motion the block stays in mode 11 for as long as ticks keep arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| motion_i | input | 1 | Motion-detected pulse |
| cfg_wr_i | input | 1 | Write strobe for the configuration byte |
| cfg_wdata_i | input | 8 | Configuration write data; bits 7:6 hold the forced-mode code |
| ctrl_wr_i | input | 1 | Write strobe for the control byte |
| ctrl_wdata_i | input | 8 | Control write data; bit 1 is power-down |
| mode_o | output | 2 | Current mode: 00 run, 01/10/11 rest 1/2/3 |
| sample_en_o | output | 1 | One-cycle strobe telling the sensor to acquire a frame |
| pd_o | output | 1 | Power-down flag |
| cfg_rdata_o | output | 8 | Configuration readback: mode in bits 7:6, zeros below |

## Verification
Some behaviour is checked by the bound properties on every cycle. These are: a strobe always follows a tick; a forced code or a release takes effect one cycle after the write; motion in automatic operation always returns the block to run; and power-down is sticky, stops all strobes and freezes the mode. Other behaviour can only be shown by the bench's scenarios, which compare against a cycle model. This covers the exact tick counts at which each downshift happens, the spacing of strobes in each rest mode, and the restart of that spacing after a mode change. It also covers saturation of the inactivity count and whether readback is correct under random mixes of ticks, motion and writes.

// File: rtl/pms_pkg.sv
`timescale 1ns/1ps
package pms_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_REST1 = 2'b01,
        MODE_REST2 = 2'b10,
        MODE_REST3 = 2'b11
    } pms_mode_e;

    localparam int unsigned CFG_CODE_HI = 7;
    localparam int unsigned CFG_CODE_LO = 6;
    localparam int unsigned CTRL_PD_BIT = 1;
    localparam int unsigned N_REST      = 3;
endpackage

// File: rtl/pms_idle_timer.sv
`timescale 1ns/1ps
module pms_idle_timer
    import pms_pkg::*;
#(
    parameter int unsigned IDLE1_TICKS = 1000,
    parameter int unsigned IDLE2_TICKS = 7000,
    parameter int unsigned IDLE3_TICKS = 410000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      motion_i,
    input  logic      clear_i,
    input  logic      hold_i,
    output pms_mode_e lvl_next_o
);
    localparam int unsigned IDLE_W = $clog2(IDLE3_TICKS + 1);
    localparam logic [IDLE_W-1:0] THR [N_REST] = '{
        IDLE_W'(IDLE1_TICKS), IDLE_W'(IDLE2_TICKS), IDLE_W'(IDLE3_TICKS)
    };

    typedef struct packed {
        logic [IDLE_W-1:0] idle;
    } tmr_st_t;

    tmr_st_t           st_d, st_q;
    logic [N_REST-1:0] reach;

    // Next inactivity count: motion or release clears, ticks count up to a ceiling.
    always_comb begin
        st_d = st_q;
        if (!hold_i) begin
            if (motion_i || clear_i) begin
                st_d.idle = '0;
            end else if (tick_i && (st_q.idle < THR[N_REST-1])) begin
                st_d.idle = st_q.idle + 1'b1;
            end
        end
    end

    // One comparator per rest level against the next count.
    generate
        for (genvar k = 0; k < N_REST; k++) begin : g_reach
            assign reach[k] = (st_d.idle >= THR[k]);
        end
    endgenerate

    // Deepest level reached wins.
    always_comb begin
        lvl_next_o = MODE_RUN;
        for (int k = 0; k < N_REST; k++) begin
            if (reach[k]) begin
                lvl_next_o = pms_mode_e'(2'(k + 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pms_period_gen.sv
`timescale 1ns/1ps
module pms_period_gen
    import pms_pkg::*;
#(
    parameter int unsigned POLL1_TICKS = 14,
    parameter int unsigned POLL2_TICKS = 68,
    parameter int unsigned POLL3_TICKS = 340
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      hold_i,
    input  pms_mode_e mode_i,
    input  pms_mode_e mode_next_i,
    output logic      sample_o
);
    localparam int unsigned P12   = (POLL1_TICKS > POLL2_TICKS) ? POLL1_TICKS : POLL2_TICKS;
    localparam int unsigned PMAX  = (P12 > POLL3_TICKS) ? P12 : POLL3_TICKS;
    localparam int unsigned CNT_W = (PMAX > 1) ? $clog2(PMAX) : 1;
    // Last count value before a strobe, indexed by mode code; run strobes every tick.
    localparam logic [CNT_W-1:0] LIM [4] = '{
        '0, CNT_W'(POLL1_TICKS - 1), CNT_W'(POLL2_TICKS - 1), CNT_W'(POLL3_TICKS - 1)
    };

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sample;
    } pg_st_t;

    pg_st_t st_d, st_q;
    logic   hit;

    always_comb begin
        st_d        = st_q;
        st_d.sample = 1'b0;
        hit         = (st_q.cnt >= LIM[mode_i]);
        if (tick_i && !hold_i) begin
            st_d.sample = hit;
            st_d.cnt    = hit ? '0 : st_q.cnt + 1'b1;
        end
        if (mode_next_i != mode_i) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o = st_q.sample;
endmodule

// File: rtl/pms_mode_ctrl.sv
`timescale 1ns/1ps
module pms_mode_ctrl
    import pms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr_i,
    input  logic [1:0] cfg_code_i,
    input  logic       ctrl_wr_i,
    input  logic       ctrl_pd_i,
    input  pms_mode_e  lvl_next_i,
    output pms_mode_e  mode_o,
    output pms_mode_e  mode_next_o,
    output logic       pd_o,
    output logic       release_o
);
    typedef struct packed {
        pms_mode_e  mode;
        logic [1:0] frc;
        logic       pd;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.pd) begin
            if (cfg_wr_i) begin
                st_d.frc = cfg_code_i;
            end
            if (ctrl_wr_i && ctrl_pd_i) begin
                st_d.pd = 1'b1;
            end
            st_d.mode = (st_d.frc != 2'b00) ? pms_mode_e'(st_d.frc) : lvl_next_i;
        end
    end

    assign release_o   = cfg_wr_i && (cfg_code_i == 2'b00) && !st_q.pd;
    assign mode_next_o = st_d.mode;
    assign mode_o      = st_q.mode;
    assign pd_o        = st_q.pd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RUN, frc: 2'b00, pd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwr_mode_seq.sv
`timescale 1ns/1ps
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int unsigned POLL1_TICKS = 14,
    parameter int unsigned POLL2_TICKS = 68,
    parameter int unsigned POLL3_TICKS = 340,
    parameter int unsigned IDLE1_TICKS = 1000,
    parameter int unsigned IDLE2_TICKS = 7000,
    parameter int unsigned IDLE3_TICKS = 410000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       motion_i,
    input  logic       cfg_wr_i,
    input  logic [7:0] cfg_wdata_i,
    input  logic       ctrl_wr_i,
    input  logic [7:0] ctrl_wdata_i,
    output logic [1:0] mode_o,
    output logic       sample_en_o,
    output logic       pd_o,
    output logic [7:0] cfg_rdata_o
);
    pms_mode_e lvl_next;
    pms_mode_e mode_q;
    pms_mode_e mode_next;
    logic      release_w;
    logic      pd_w;
    logic      unused_wdata;

    assign unused_wdata = ^{cfg_wdata_i[CFG_CODE_LO-1:0],
                            ctrl_wdata_i[7:CTRL_PD_BIT+1],
                            ctrl_wdata_i[CTRL_PD_BIT-1:0]};

    pms_idle_timer #(
        .IDLE1_TICKS(IDLE1_TICKS),
        .IDLE2_TICKS(IDLE2_TICKS),
        .IDLE3_TICKS(IDLE3_TICKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .motion_i   (motion_i),
        .clear_i    (release_w),
        .hold_i     (pd_w),
        .lvl_next_o (lvl_next)
    );

    pms_mode_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_code_i  (cfg_wdata_i[CFG_CODE_HI:CFG_CODE_LO]),
        .ctrl_wr_i   (ctrl_wr_i),
        .ctrl_pd_i   (ctrl_wdata_i[CTRL_PD_BIT]),
        .lvl_next_i  (lvl_next),
        .mode_o      (mode_q),
        .mode_next_o (mode_next),
        .pd_o        (pd_w),
        .release_o   (release_w)
    );

    pms_period_gen #(
        .POLL1_TICKS(POLL1_TICKS),
        .POLL2_TICKS(POLL2_TICKS),
        .POLL3_TICKS(POLL3_TICKS)
    ) u_period (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .hold_i      (pd_w),
        .mode_i      (mode_q),
        .mode_next_i (mode_next),
        .sample_o    (sample_en_o)
    );

    assign mode_o      = mode_q;
    assign pd_o        = pd_w;
    assign cfg_rdata_o = {mode_q, {CFG_CODE_LO{1'b0}}};
endmodule

// File: rtl/pms_checker.sv
`timescale 1ns/1ps
module pms_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       motion_i,
    input logic       cfg_wr_i,
    input logic [1:0] cfg_code_i,
    input logic       ctrl_wr_i,
    input logic       ctrl_pd_i,
    input logic [1:0] mode_o,
    input logic       sample_en_o,
    input logic       pd_o
);
    // Tracks whether the block runs automatically, from the write stream alone.
    logic auto_q;
    logic auto_after;

    assign auto_after = cfg_wr_i ? (cfg_code_i == 2'b00) : auto_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q <= 1'b1;
        end else if (!pd_o) begin
            auto_q <= auto_after;
        end
    end

    assert_motion_to_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (motion_i && !pd_o && auto_after) |=> (mode_o == 2'b00));

    assert_strobe_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_o |-> $past(tick_i));

    assert_force_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && (cfg_code_i != 2'b00) && !pd_o) |=> (mode_o == $past(cfg_code_i)));

    assert_release_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && (cfg_code_i == 2'b00) && !pd_o) |=> (mode_o == 2'b00));

    assert_pd_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && ctrl_pd_i) |=> pd_o);

    assert_pd_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pd_o |=> pd_o);

    assert_pd_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pd_o |=> !sample_en_o);

    assert_pd_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pd_o |=> $stable(mode_o));
endmodule

bind pwr_mode_seq pms_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .motion_i    (motion_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_code_i  (cfg_wdata_i[7:6]),
    .ctrl_wr_i   (ctrl_wr_i),
    .ctrl_pd_i   (ctrl_wdata_i[1]),
    .mode_o      (mode_o),
    .sample_en_o (sample_en_o),
    .pd_o        (pd_o)
);

// File: tb/pwr_mode_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_seq_tb_top;
    localparam int P1 = 3;
    localparam int P2 = 5;
    localparam int P3 = 7;
    localparam int T1 = 20;
    localparam int T2 = 50;
    localparam int T3 = 120;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       motion_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic       ctrl_wr_i = 1'b0;
    logic [7:0] ctrl_wdata_i = 8'h00;
    logic [1:0] mode_o;
    logic       sample_en_o;
    logic       pd_o;
    logic [7:0] cfg_rdata_o;

    int n_chk = 0;
    int n_err = 0;

    // Reference state built from the requirements.
    int m_idle, m_cnt;
    int m_mode, m_frc;
    bit m_pd, m_sample;

    always #4 clk = ~clk;

    pwr_mode_seq #(
        .POLL1_TICKS(P1), .POLL2_TICKS(P2), .POLL3_TICKS(P3),
        .IDLE1_TICKS(T1), .IDLE2_TICKS(T2), .IDLE3_TICKS(T3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .motion_i(motion_i),
        .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
        .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
        .mode_o(mode_o), .sample_en_o(sample_en_o), .pd_o(pd_o),
        .cfg_rdata_o(cfg_rdata_o)
    );

    function automatic int lvl_of(int idle);
        if (idle >= T3) return 3;
        if (idle >= T2) return 2;
        if (idle >= T1) return 1;
        return 0;
    endfunction

    function automatic int per_of(int mode);
        case (mode)
            1: return P1;
            2: return P2;
            3: return P3;
            default: return 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_idle = 0; m_cnt = 0; m_mode = 0; m_frc = 0; m_pd = 0; m_sample = 0;
    endtask

    task automatic model_edge(bit t, bit m, bit cw, logic [7:0] cd, bit pw, logic [7:0] pdat);
        int old_mode;
        bit hit;
        if (m_pd) begin
            m_sample = 0;
            return;
        end
        old_mode = m_mode;
        hit      = (old_mode == 0) || (m_cnt == per_of(old_mode) - 1);
        m_sample = t && hit;
        if (t) m_cnt = hit ? 0 : m_cnt + 1;
        if (cw) m_frc = int'(cd[7:6]);
        if (m || (cw && cd[7:6] == 2'b00)) m_idle = 0;
        else if (t && m_idle < T3) m_idle++;
        m_mode = (m_frc != 0) ? m_frc : lvl_of(m_idle);
        if (m_mode != old_mode) m_cnt = 0;
        if (pw && pdat[1]) m_pd = 1;
    endtask

    task automatic compare_all();
        check(mode_o == 2'(m_mode), "R2 R3 R6 R7 mode_o", mode_o, m_mode);
        check(sample_en_o == m_sample, "R4 R5 sample_en_o", sample_en_o, m_sample);
        check(pd_o == m_pd, "R9 R10 pd_o", pd_o, m_pd);
        check(cfg_rdata_o == {2'(m_mode), 6'b0}, "R8 cfg_rdata_o", cfg_rdata_o, {2'(m_mode), 6'b0});
    endtask

    task automatic drive(bit t, bit m, bit cw, logic [7:0] cd, bit pw, logic [7:0] pdat);
        @(negedge clk);
        tick_i = t; motion_i = m; cfg_wr_i = cw; cfg_wdata_i = cd;
        ctrl_wr_i = pw; ctrl_wdata_i = pdat;
        @(posedge clk);
        model_edge(t, m, cw, cd, pw, pdat);
        #1;
        compare_all();
    endtask

    task automatic step(bit t, bit m);
        drive(t, m, 1'b0, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_i = 0; motion_i = 0; cfg_wr_i = 0; ctrl_wr_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int strobes;
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();
        #1;
        // R1: reset state
        check(mode_o == 2'b00, "R1 mode after reset", mode_o, 0);
        check(sample_en_o == 1'b0, "R1 strobe after reset", sample_en_o, 0);
        check(pd_o == 1'b0, "R1 pd after reset", pd_o, 0);
        check(cfg_rdata_o == 8'h00, "R1 readback after reset", cfg_rdata_o, 0);

        // R2: downshift at the exact thresholds
        for (int i = 1; i <= T3 + 30; i++) begin
            step(1'b1, 1'b0);
            if (i == T1 - 1) check(mode_o == 2'b00, "R2 before first threshold", mode_o, 0);
            if (i == T1)     check(mode_o == 2'b01, "R2 at first threshold", mode_o, 1);
            if (i == T2)     check(mode_o == 2'b10, "R2 at second threshold", mode_o, 2);
            if (i == T3)     check(mode_o == 2'b11, "R2 at third threshold", mode_o, 3);
        end
        // R11: saturated in the deepest rest mode
        check(mode_o == 2'b11, "R11 stays in rest 3", mode_o, 3);

        // R5: two strobes in any window of 2*P3 ticks in rest 3
        strobes = 0;
        for (int i = 0; i < 2 * P3; i++) begin
            step(1'b1, 1'b0);
            if (sample_en_o) strobes++;
        end
        check(strobes == 2, "R5 rest 3 strobe spacing", strobes, 2);

        // R3: motion together with a tick returns to run
        step(1'b1, 1'b1);
        check(mode_o == 2'b00, "R3 motion wakes to run", mode_o, 0);
        // R4: every tick strobes in run
        strobes = 0;
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b0);
            if (sample_en_o) strobes++;
        end
        check(strobes == 6, "R4 strobe on each run tick", strobes, 6);

        // R6 and R8: forced rest 2, junk in low bits
        drive(1'b0, 1'b0, 1'b1, 8'hBF, 1'b0, 8'h00);
        check(mode_o == 2'b10, "R6 forced mode", mode_o, 2);
        check(cfg_rdata_o == 8'h80, "R8 forced readback", cfg_rdata_o, 8'h80);
        step(1'b1, 1'b1);
        check(mode_o == 2'b10, "R6 motion does not leave forced mode", mode_o, 2);
        for (int i = 0; i < T3 + 5; i++) step(1'b1, 1'b0);
        check(mode_o == 2'b10, "R6 forced mode ignores inactivity", mode_o, 2);

        // R7: release with junk low bits, count restarts from zero
        drive(1'b0, 1'b0, 1'b1, 8'h15, 1'b0, 8'h00);
        check(mode_o == 2'b00, "R7 release to run", mode_o, 0);
        check(cfg_rdata_o == 8'h00, "R8 readback after release", cfg_rdata_o, 0);
        for (int i = 0; i < T1 - 1; i++) step(1'b1, 1'b0);
        check(mode_o == 2'b00, "R7 inactivity count cleared", mode_o, 0);
        step(1'b1, 1'b0);
        check(mode_o == 2'b01, "R7 downshift after release", mode_o, 1);

        // Random mix, checked against the reference each cycle
        for (int i = 0; i < 3000; i++) begin
            bit t, m, cw, pw;
            logic [7:0] cd, pdat;
            t    = ($urandom % 2) == 0;
            m    = ($urandom % 60) == 0;
            cw   = ($urandom % 150) == 0;
            cd   = (($urandom % 3) == 0) ? 8'(($urandom % 4) << 6) | 8'($urandom % 64)
                                         : 8'($urandom % 64);
            pw   = ($urandom % 100) == 0;
            pdat = 8'($urandom) & 8'hFD;
            drive(t, m, cw, cd, pw, pdat);
        end
        // R9: control write without bit 1 changes nothing
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFD);
        check(pd_o == 1'b0, "R9 other control bits ignored", pd_o, 0);

        // R9: power-down set
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h02);
        check(pd_o == 1'b1, "R9 power-down raised", pd_o, 1);
        // R10: everything frozen while powered down
        strobes = 0;
        for (int i = 0; i < 40; i++) begin
            drive(1'b1, (i % 5) == 0, (i % 7) == 0, 8'hC0, 1'b0, 8'h00);
            if (sample_en_o) strobes++;
        end
        check(strobes == 0, "R10 no strobes in power-down", strobes, 0);
        check(mode_o == 2'(m_mode), "R10 mode held in power-down", mode_o, m_mode);
        check(pd_o == 1'b1, "R10 power-down sticky", pd_o, 1);
        do_reset();
        #1;
        check(pd_o == 1'b0, "R10 reset clears power-down", pd_o, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule